// File: doc/BRIEF.md
# I2C Arbitration-Lost Detector

This block watches a shared two-wire bus while the local controller is transmitting. On every rising edge of the clock line it compares the data bit the controller is driving with the level actually present on the data line. A disagreement means another controller is driving the bus, so the local side has lost arbitration. The block raises a sticky flag that software reads.

The flag has two update styles, picked by a mode input. In per-bit style the flag goes up in the cycle after the offending clock rise. In per-byte style a mismatch is only remembered internally. The stored mismatch is posted to the flag when the clock line falls while the ninth-clock indicator is high, which is the end of the acknowledge slot. The internal memory is emptied when it is posted and when a start condition appears on the bus. Software then has the gap between that acknowledge and the next byte to read and clear the flag.

Both bus lines arrive already synchronized to the system clock. Data bits are compared only while the transmit-active qualifier is high. This also covers the acknowledge slot: the ninth bit is compared only if the controller itself drives it.

Top module: `i2c_arb_loss_det`

## Requirements
- R1: After reset, `arb_lost_o` is 0.
- R2: With `byte_mode_i`=0, a clock-line rise (`scl_i` 0 in the previous cycle, 1 now) with `tx_active_i`=1 and `tx_bit_i` different from `sda_i` sets `arb_lost_o` to 1 from the next cycle.
- R3: While `tx_active_i`=0, a mismatch at a clock-line rise is not recorded, in either mode.
- R4: A clock-line rise where `tx_bit_i` equals `sda_i` does not set the flag.
- R5: With `byte_mode_i`=1, a mismatch leaves `arb_lost_o` unchanged until the clock line falls while `ninth_i`=1. The flag then reads 1 from the cycle after that fall.
- R6: With `byte_mode_i`=1, a clock-line fall while `ninth_i`=0 does not post a stored mismatch.
- R7: Posting empties the stored mismatch. After a clear, the next ninth-clock fall with no new mismatch leaves the flag at 0.
- R8: A start condition empties the stored mismatch. A start condition is `sda_i` falling while `scl_i` is 1 in both this cycle and the previous one.
- R9: Once set, `arb_lost_o` stays 1 until `clr_i` is pulsed. It reads 0 in the cycle after a clear that has no competing set.
- R10: If a set and `clr_i` land in the same cycle, the set wins and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized clock-line level |
| sda_i | input | 1 | Synchronized data-line level |
| tx_bit_i | input | 1 | Bit the local transmitter is driving |
| tx_active_i | input | 1 | High while the local side is transmitting the current bit |
| byte_mode_i | input | 1 | 0: flag updates per bit; 1: flag posted once per byte |
| ninth_i | input | 1 | High during the ninth (acknowledge) clock of a byte |
| clr_i | input | 1 | Software clear strobe for the flag |
| arb_lost_o | output | 1 | Sticky arbitration-lost flag |

## Verification
The bench tests per-bit mode with matching bits, mismatching bits and mismatches while transmit-active is low. This separates the real comparison from a bare edge detector and from a missing qualifier. In per-byte mode it places a mismatch early in a byte and checks that no ordinary clock fall posts it, but the ninth-clock fall does. It then runs a clean byte after a clear, which shows whether posting empties the internal memory. A mismatch followed by a start condition shows whether the start resets that memory. A clear timed onto the same cycle as a setting clock rise shows which of the two wins.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

   typedef struct packed {
      logic rise;
      logic fall;
      logic start;
   } bus_evt_t;

endpackage

// File: rtl/arb_bus_events.sv
module arb_bus_events
   import i2c_arb_pkg::*;
#(
   parameter bit IDLE_LEVEL = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output bus_evt_t evt_o
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= IDLE_LEVEL;
         sda_q <= IDLE_LEVEL;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   always_comb begin
      evt_o.rise  = scl_i & ~scl_q;
      evt_o.fall  = ~scl_i & scl_q;
      evt_o.start = sda_q & ~sda_i & scl_i & scl_q;
   end

endmodule

// File: rtl/arb_bit_compare.sv
module arb_bit_compare
   import i2c_arb_pkg::*;
(
   input  bus_evt_t evt_i,
   input  logic     sda_i,
   input  logic     tx_bit_i,
   input  logic     tx_active_i,
   output logic     mismatch_o
);

   logic differ;

   always_comb begin
      differ     = tx_bit_i ^ sda_i;
      mismatch_o = evt_i.rise & tx_active_i & differ;
   end

endmodule

// File: rtl/arb_flag_ctrl.sv
module arb_flag_ctrl
   import i2c_arb_pkg::*;
#(
   parameter int SUPPORT_BYTE_MODE = 1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  bus_evt_t evt_i,
   input  logic     mismatch_i,
   input  logic     byte_mode_i,
   input  logic     ninth_i,
   input  logic     clr_i,
   output logic     flag_o
);

   logic set_evt;
   logic flag_q;

   generate
      if (SUPPORT_BYTE_MODE != 0) begin : g_byte
         logic pend_q;
         logic post;
         always_comb post = evt_i.fall & ninth_i;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q <= 1'b0;
            end else if (!byte_mode_i) begin
               pend_q <= 1'b0;
            end else if (post || evt_i.start) begin
               pend_q <= 1'b0;
            end else if (mismatch_i) begin
               pend_q <= 1'b1;
            end
         end
         always_comb set_evt = byte_mode_i ? (post & pend_q) : mismatch_i;
      end else begin : g_bit
         always_comb set_evt = mismatch_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (set_evt) begin
         flag_q <= 1'b1;
      end else if (clr_i) begin
         flag_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/i2c_arb_loss_det.sv
module i2c_arb_loss_det
   import i2c_arb_pkg::*;
#(
   parameter int SUPPORT_BYTE_MODE = 1,
   parameter bit IDLE_LEVEL        = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic tx_bit_i,
   input  logic tx_active_i,
   input  logic byte_mode_i,
   input  logic ninth_i,
   input  logic clr_i,
   output logic arb_lost_o
);

   generate
      if (SUPPORT_BYTE_MODE != 0 && SUPPORT_BYTE_MODE != 1) begin : g_bad_param
         $error("SUPPORT_BYTE_MODE must be 0 or 1");
      end
   endgenerate

   bus_evt_t evt;
   logic     mismatch;

   arb_bus_events #(.IDLE_LEVEL(IDLE_LEVEL)) u_events (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .evt_o (evt)
   );

   arb_bit_compare u_cmp (
      .evt_i       (evt),
      .sda_i       (sda_i),
      .tx_bit_i    (tx_bit_i),
      .tx_active_i (tx_active_i),
      .mismatch_o  (mismatch)
   );

   arb_flag_ctrl #(.SUPPORT_BYTE_MODE(SUPPORT_BYTE_MODE)) u_flag (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt),
      .mismatch_i  (mismatch),
      .byte_mode_i (byte_mode_i),
      .ninth_i     (ninth_i),
      .clr_i       (clr_i),
      .flag_o      (arb_lost_o)
   );

endmodule

// File: rtl/i2c_arb_loss_det_chk.sv
module i2c_arb_loss_det_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_i,
   input logic tx_bit_i,
   input logic tx_active_i,
   input logic byte_mode_i,
   input logic clr_i,
   input logic arb_lost_o
);

   AST_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_mode_i && tx_active_i && $rose(scl_i) && (tx_bit_i != sda_i)) |=> arb_lost_o); // R2

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !byte_mode_i && tx_active_i && $rose(scl_i) && (tx_bit_i != sda_i)) |=> arb_lost_o); // R10

   AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_active_i && !byte_mode_i && !arb_lost_o) |=> !arb_lost_o); // R3

   AST_BYTE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_mode_i && !arb_lost_o && !$fell(scl_i)) |=> !arb_lost_o); // R5

   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_lost_o && !clr_i) |=> arb_lost_o); // R9

   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !$rose(scl_i) && !$fell(scl_i)) |=> !arb_lost_o); // R9

endmodule

bind i2c_arb_loss_det i2c_arb_loss_det_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_i       (scl_i),
   .sda_i       (sda_i),
   .tx_bit_i    (tx_bit_i),
   .tx_active_i (tx_active_i),
   .byte_mode_i (byte_mode_i),
   .clr_i       (clr_i),
   .arb_lost_o  (arb_lost_o)
);

// File: tb/test_i2c_arb_loss_det.sv
module test_i2c_arb_loss_det;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda = 1'b1, tx_bit = 1'b1, tx_act = 1'b0;
   logic bmode = 1'b0, ninth = 1'b0, clr = 1'b0;
   logic arb_lost;

   int checks = 0;
   int fails = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_arb_loss_det i_i2c_arb_loss_det (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
      .tx_bit_i(tx_bit), .tx_active_i(tx_act), .byte_mode_i(bmode),
      .ninth_i(ninth), .clr_i(clr), .arb_lost_o(arb_lost)
   );

   // behavioural reference
   bit m_flag, m_pend, m_scl, m_sda;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_flag = 0; m_pend = 0; m_scl = 1; m_sda = 1;
      end else begin
         bit rise, fall, start, miss, setev;
         rise  = scl && !m_scl;
         fall  = !scl && m_scl;
         start = m_sda && !sda && scl && m_scl;
         miss  = rise && tx_act && (tx_bit != sda);
         if (bmode) begin
            setev = fall && ninth && m_pend;
            if ((fall && ninth) || start) m_pend = 0;
            else if (miss) m_pend = 1;
         end else begin
            setev = miss;
            m_pend = 0;
         end
         if (setev) m_flag = 1;
         else if (clr) m_flag = 0;
         m_scl = scl;
         m_sda = sda;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (arb_lost !== m_flag) begin
            fails++;
            $display("FAIL %s model: arb_lost=%0b expected=%0b at %0t", cur_req, arb_lost, m_flag, $time);
         end
      end
   end

   task automatic check(input string req, input logic exp);
      checks++;
      if (arb_lost !== exp) begin
         fails++;
         $display("FAIL %s: arb_lost=%0b expected=%0b", req, arb_lost, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send_bit(input logic tb, input logic line, input logic act, input logic nin);
      ninth = nin; tx_bit = tb; tx_act = act; sda = line; scl = 0;
      wait_n(2);
      scl = 1;
      wait_n(2);
      scl = 0;
      wait_n(1);
   endtask

   task automatic send_start();
      scl = 0; sda = 1; wait_n(1);
      scl = 1; wait_n(2);
      sda = 0; wait_n(2);
      scl = 0; wait_n(1);
   endtask

   task automatic pulse_clr();
      clr = 1; wait_n(1); clr = 0; wait_n(1);
   endtask

   initial begin
      wait_n(3);
      check("R1", 1'b0);
      rst_n = 1;
      wait_n(2);
      check("R1", 1'b0);

      // per-bit mode
      cur_req = "R4";
      send_start();
      for (int i = 0; i < 8; i++) send_bit(i[0], i[0], 1, 0);
      check("R4", 1'b0);
      cur_req = "R3";
      send_bit(1, 0, 0, 0);
      send_bit(0, 1, 0, 1);
      check("R3", 1'b0);
      cur_req = "R2";
      send_bit(1, 0, 1, 0);
      check("R2", 1'b1);
      cur_req = "R9";
      send_bit(0, 0, 1, 0);
      wait_n(3);
      check("R9", 1'b1);
      pulse_clr();
      check("R9", 1'b0);

      // set and clear collide
      cur_req = "R10";
      ninth = 0; tx_bit = 1; tx_act = 1; sda = 0; scl = 0;
      wait_n(2);
      scl = 1; clr = 1;
      wait_n(1);
      clr = 0;
      check("R10", 1'b1);
      wait_n(1); scl = 0; wait_n(1);
      pulse_clr();
      check("R10", 1'b0);

      // per-byte mode
      bmode = 1;
      cur_req = "R5";
      send_start();
      send_bit(1, 0, 1, 0);
      check("R5", 1'b0);
      cur_req = "R6";
      for (int i = 0; i < 7; i++) send_bit(0, 0, 1, 0);
      check("R6", 1'b0);
      cur_req = "R5";
      send_bit(1, 0, 0, 1);
      check("R5", 1'b1);
      pulse_clr();
      check("R9", 1'b0);

      cur_req = "R7";
      for (int i = 0; i < 8; i++) send_bit(1, 1, 1, 0);
      send_bit(1, 0, 0, 1);
      check("R7", 1'b0);

      cur_req = "R8";
      send_bit(0, 1, 1, 0);
      send_start();
      for (int i = 0; i < 8; i++) send_bit(1, 1, 1, 0);
      send_bit(1, 0, 0, 1);
      check("R8", 1'b0);

      cur_req = "R3";
      for (int i = 0; i < 8; i++) send_bit(1, 0, 0, 0);
      send_bit(1, 0, 0, 1);
      check("R3", 1'b0);

      cur_req = "R5";
      for (int i = 0; i < 8; i++) send_bit(1, 1, 1, 0);
      send_bit(1, 0, 1, 1);
      check("R5", 1'b1);

      wait_n(4);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule